// File: doc/BRIEF.md
# Packetised Double-Rate Memory Channel Interface

This block moves memory requests over a narrow packet channel. The host hands it a parallel row address, column address and data word, each with its own valid/ready handshake. The block turns each one into a packet on its own lane: a 3-bit row lane, a 5-bit column lane and a data lane. The data lane is 16 bits wide, or 18 bits wide when check bits are enabled. A receive path on each lane rebuilds the parallel word from the incoming beats. It reports the word with a one-cycle valid pulse.

The channel moves one beat on each edge of the channel clock, so a packet lasts four channel cycles and spans eight beat slots. The block models the double-rate timing with a beat clock at twice the channel rate. Each `clk` cycle is one beat slot. A free-running slot counter shared by all lanes frames packets. Slot 0 is the rising edge that opens a packet, and the `chanRise` output marks the slots that fall on a rising channel edge. The row packet carries 12 bits and the column packet carries 20 bits. Each address lane therefore sends four beats, and each of those beats covers one full channel cycle. The data packet carries 128 bits, or 144 bits with check bits, as eight beats of one slot each. Bank scheduling, electrical signalling and clock recovery are outside this block.

Top module: `pbus_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `slotIdx` is 0, every transmit lane valid is low and every receive output valid is low.
- R2: Each `*InRdy` is high only in the cycle where `slotIdx` is 7. A word is taken when its valid and ready are both high at a rising edge of `clk`.
- R3: A data packet starts in the slot-0 cycle that follows the accept. In slot s (0..7), `datLane` carries bits [s*W +: W] of the accepted word, lowest slice first. W is 18 when `CHK_EN`=1 (144-bit packet) and 16 when `CHK_EN`=0 (128-bit packet).
- R4: Address beat k (0..3) is held on its lane for slots 2k and 2k+1. The row lane carries bits [3k +: 3] of the 12-bit row word. The column lane carries bits [5k +: 5] of the 20-bit column word.
- R5: A lane valid is high for exactly the eight slots of a packet it is sending and low in frames with no accepted word. It changes only at slot 0.
- R6: A word accepted in the slot 7 that ends a packet starts the next packet with no idle slot between the two.
- R7: When all beats of a packet arrive with the receive valid high, the receive output shows the rebuilt word. Its valid is high for exactly one cycle, the slot-0 cycle right after the last beat.
- R8: If the receive valid is low for any beat of a packet, that lane raises no output valid for that packet.
- R9: The three lanes are independent. A handshake on one lane starts no packet and raises no output valid on another lane.
- R10: `slotIdx` counts 0 to 7 and wraps. `chanRise` is high in even slots and low in odd slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, two cycles per channel cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| rowInVld | input | 1 | Row word valid |
| rowInRdy | output | 1 | Row word ready |
| rowIn | input | 12 | Row address word |
| colInVld | input | 1 | Column word valid |
| colInRdy | output | 1 | Column word ready |
| colIn | input | 20 | Column address word |
| datInVld | input | 1 | Data word valid |
| datInRdy | output | 1 | Data word ready |
| datIn | input | 144 | Data word (128 bits when check bits are off) |
| slotIdx | output | 3 | Current beat slot in the packet frame |
| chanRise | output | 1 | Slot falls on a rising channel clock edge |
| rowLane | output | 3 | Row lane transmit beat |
| rowLaneVld | output | 1 | Row lane carrying a packet |
| colLane | output | 5 | Column lane transmit beat |
| colLaneVld | output | 1 | Column lane carrying a packet |
| datLane | output | 18 | Data lane transmit beat (16 without check bits) |
| datLaneVld | output | 1 | Data lane carrying a packet |
| rxRowLane | input | 3 | Row lane receive beat |
| rxRowLaneVld | input | 1 | Row lane receive valid |
| rxColLane | input | 5 | Column lane receive beat |
| rxColLaneVld | input | 1 | Column lane receive valid |
| rxDatLane | input | 18 | Data lane receive beat (16 without check bits) |
| rxDatLaneVld | input | 1 | Data lane receive valid |
| rowOut | output | 12 | Rebuilt row word |
| rowOutVld | output | 1 | Row word pulse |
| colOut | output | 20 | Rebuilt column word |
| colOutVld | output | 1 | Column word pulse |
| datOut | output | 144 | Rebuilt data word (128 without check bits) |
| datOutVld | output | 1 | Data word pulse |

## Verification
A slot counter that is out of step would show at once as `*InRdy` in the wrong cycle. It would also show as `chanRise` with the wrong parity, within the first frame after reset. If a transmit shift register advanced at the wrong slot, the wrong slice would appear on a lane in the very slot it slipped. That shows most clearly on the address lanes, where each beat must stay in place for two slots. A receive path that lost a beat or mishandled completeness would show eight cycles after the accept, in the slot-0 cycle where the output word and its single-cycle valid are checked against the word that was sent. The bench loops each lane back and can blank the receive valid in a chosen slot.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int SLOTS  = 8;
  localparam int SLOT_W = $clog2(SLOTS);

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic              frameStart;
    logic              frameEnd;
  } pbus_stb_t;
endpackage

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  output pbus_stb_t stb,
  output logic      chanRise
);
  logic [SLOT_W-1:0] slotQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotQ <= '0;
    else       slotQ <= slotQ + 1'b1;
  end

  always_comb begin
    stb.slot       = slotQ;
    stb.frameStart = (slotQ == '0);
    stb.frameEnd   = (slotQ == SLOT_W'(SLOTS - 1));
  end

  assign chanRise = ~slotQ[0];

  // R10
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameEnd |=> stb.frameStart);
endmodule

// File: rtl/pbus_lane.sv
module pbus_lane
  import pbus_pkg::*;
#(
  parameter int LW   = 3,
  parameter int BITS = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  pbus_stb_t       stb,
  input  logic            inVld,
  output logic            inRdy,
  input  logic [BITS-1:0] inWord,
  output logic [LW-1:0]   txLane,
  output logic            txVld,
  input  logic [LW-1:0]   rxLane,
  input  logic            rxVld,
  output logic [BITS-1:0] outWord,
  output logic            outVld
);
  localparam int BEATS = BITS / LW;
  localparam int STEP  = SLOTS / BEATS;
  localparam int SH    = $clog2(STEP);

  logic              beatEnd;
  logic [SLOT_W-1:0] beatIdx;
  logic [BITS-1:0]   txShift;
  logic [BITS-1:0]   asmReg;
  logic              allGood;

  generate
    if (STEP == 1) begin : g_fullRate
      assign beatEnd = 1'b1;
    end else begin : g_slowRate
      assign beatEnd = (stb.slot & SLOT_W'(STEP - 1)) == SLOT_W'(STEP - 1);
    end
  endgenerate

  assign beatIdx = stb.slot >> SH;
  assign inRdy   = stb.frameEnd;
  assign txLane  = txShift[LW-1:0];

  // transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      txVld   <= 1'b0;
    end else if (stb.frameEnd) begin
      if (inVld) begin
        txShift <= inWord;
        txVld   <= 1'b1;
      end else begin
        txShift <= '0;
        txVld   <= 1'b0;
      end
    end else if (beatEnd) begin
      txShift <= txShift >> LW;
    end
  end

  // receive assembler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asmReg  <= '0;
      allGood <= 1'b0;
      outWord <= '0;
      outVld  <= 1'b0;
    end else begin
      outVld <= 1'b0;
      if (beatEnd) begin
        asmReg[int'(beatIdx)*LW +: LW] <= rxLane;
        allGood <= (beatIdx == '0) ? rxVld : (allGood & rxVld);
      end
      if (stb.frameEnd) begin
        outVld  <= rxVld & allGood;
        outWord <= {rxLane, asmReg[BITS-LW-1:0]};
      end
    end
  end

  // R5
  tx_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txVld) |-> stb.frameStart);
  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.frameStart |-> $stable(txVld));
  // R7
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outVld |=> !outVld);
  // R7
  rx_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    outVld |-> stb.frameStart);
  // R8
  rx_complete_chk: assert property (@(posedge clk) disable iff (!rstN)
    outVld |-> $past(rxVld));
endmodule

// File: rtl/pbus_datapath.sv
module pbus_datapath
  import pbus_pkg::*;
#(
  parameter int ROW_LW = 3,
  parameter int ROW_BITS = 12,
  parameter int COL_LW = 5,
  parameter int COL_BITS = 20,
  parameter int DAT_LW = 18,
  parameter int DAT_BITS = 144
) (
  input  logic                clk,
  input  logic                rstN,
  input  pbus_stb_t           stb,
  input  logic                rowInVld,
  output logic                rowInRdy,
  input  logic [ROW_BITS-1:0] rowIn,
  input  logic                colInVld,
  output logic                colInRdy,
  input  logic [COL_BITS-1:0] colIn,
  input  logic                datInVld,
  output logic                datInRdy,
  input  logic [DAT_BITS-1:0] datIn,
  output logic [ROW_LW-1:0]   rowLane,
  output logic                rowLaneVld,
  output logic [COL_LW-1:0]   colLane,
  output logic                colLaneVld,
  output logic [DAT_LW-1:0]   datLane,
  output logic                datLaneVld,
  input  logic [ROW_LW-1:0]   rxRowLane,
  input  logic                rxRowLaneVld,
  input  logic [COL_LW-1:0]   rxColLane,
  input  logic                rxColLaneVld,
  input  logic [DAT_LW-1:0]   rxDatLane,
  input  logic                rxDatLaneVld,
  output logic [ROW_BITS-1:0] rowOut,
  output logic                rowOutVld,
  output logic [COL_BITS-1:0] colOut,
  output logic                colOutVld,
  output logic [DAT_BITS-1:0] datOut,
  output logic                datOutVld
);
  pbus_lane #(.LW(ROW_LW), .BITS(ROW_BITS)) u_rowLane (
    .clk(clk), .rstN(rstN), .stb(stb),
    .inVld(rowInVld), .inRdy(rowInRdy), .inWord(rowIn),
    .txLane(rowLane), .txVld(rowLaneVld),
    .rxLane(rxRowLane), .rxVld(rxRowLaneVld),
    .outWord(rowOut), .outVld(rowOutVld));

  pbus_lane #(.LW(COL_LW), .BITS(COL_BITS)) u_colLane (
    .clk(clk), .rstN(rstN), .stb(stb),
    .inVld(colInVld), .inRdy(colInRdy), .inWord(colIn),
    .txLane(colLane), .txVld(colLaneVld),
    .rxLane(rxColLane), .rxVld(rxColLaneVld),
    .outWord(colOut), .outVld(colOutVld));

  pbus_lane #(.LW(DAT_LW), .BITS(DAT_BITS)) u_datLane (
    .clk(clk), .rstN(rstN), .stb(stb),
    .inVld(datInVld), .inRdy(datInRdy), .inWord(datIn),
    .txLane(datLane), .txVld(datLaneVld),
    .rxLane(rxDatLane), .rxVld(rxDatLaneVld),
    .outWord(datOut), .outVld(datOutVld));
endmodule

// File: rtl/pbus_top.sv
module pbus_top
  import pbus_pkg::*;
#(
  parameter int CHK_EN   = 1,
  parameter int ROW_LW   = 3,
  parameter int ROW_BITS = 12,
  parameter int COL_LW   = 5,
  parameter int COL_BITS = 20,
  parameter int DAT_BASE = 16,
  localparam int DAT_LW   = (CHK_EN != 0) ? DAT_BASE + DAT_BASE / 8 : DAT_BASE,
  localparam int DAT_BITS = DAT_LW * SLOTS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rowInVld,
  output logic                rowInRdy,
  input  logic [ROW_BITS-1:0] rowIn,
  input  logic                colInVld,
  output logic                colInRdy,
  input  logic [COL_BITS-1:0] colIn,
  input  logic                datInVld,
  output logic                datInRdy,
  input  logic [DAT_BITS-1:0] datIn,
  output logic [SLOT_W-1:0]   slotIdx,
  output logic                chanRise,
  output logic [ROW_LW-1:0]   rowLane,
  output logic                rowLaneVld,
  output logic [COL_LW-1:0]   colLane,
  output logic                colLaneVld,
  output logic [DAT_LW-1:0]   datLane,
  output logic                datLaneVld,
  input  logic [ROW_LW-1:0]   rxRowLane,
  input  logic                rxRowLaneVld,
  input  logic [COL_LW-1:0]   rxColLane,
  input  logic                rxColLaneVld,
  input  logic [DAT_LW-1:0]   rxDatLane,
  input  logic                rxDatLaneVld,
  output logic [ROW_BITS-1:0] rowOut,
  output logic                rowOutVld,
  output logic [COL_BITS-1:0] colOut,
  output logic                colOutVld,
  output logic [DAT_BITS-1:0] datOut,
  output logic                datOutVld
);
  pbus_stb_t stb;

  pbus_ctrl u_ctrl (.clk(clk), .rstN(rstN), .stb(stb), .chanRise(chanRise));

  assign slotIdx = stb.slot;

  pbus_datapath #(
    .ROW_LW(ROW_LW), .ROW_BITS(ROW_BITS), .COL_LW(COL_LW), .COL_BITS(COL_BITS),
    .DAT_LW(DAT_LW), .DAT_BITS(DAT_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rowInVld(rowInVld), .rowInRdy(rowInRdy), .rowIn(rowIn),
    .colInVld(colInVld), .colInRdy(colInRdy), .colIn(colIn),
    .datInVld(datInVld), .datInRdy(datInRdy), .datIn(datIn),
    .rowLane(rowLane), .rowLaneVld(rowLaneVld),
    .colLane(colLane), .colLaneVld(colLaneVld),
    .datLane(datLane), .datLaneVld(datLaneVld),
    .rxRowLane(rxRowLane), .rxRowLaneVld(rxRowLaneVld),
    .rxColLane(rxColLane), .rxColLaneVld(rxColLaneVld),
    .rxDatLane(rxDatLane), .rxDatLaneVld(rxDatLaneVld),
    .rowOut(rowOut), .rowOutVld(rowOutVld),
    .colOut(colOut), .colOutVld(colOutVld),
    .datOut(datOut), .datOutVld(datOutVld));
endmodule

// File: tb/sim_pbus_top.sv
`timescale 1ns/1ps
module sim_pbus_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic rowInVld = 0, colInVld = 0, datInVld = 0;
  logic rowInRdy, colInRdy, datInRdy;
  logic [11:0] rowIn = '0;
  logic [19:0] colIn = '0;
  logic [143:0] datIn = '0;
  logic [2:0] slotIdx;
  logic chanRise;
  logic [2:0] rowLane; logic rowLaneVld;
  logic [4:0] colLane; logic colLaneVld;
  logic [17:0] datLane; logic datLaneVld;
  logic [11:0] rowOut; logic rowOutVld;
  logic [19:0] colOut; logic colOutVld;
  logic [143:0] datOut; logic datOutVld;
  logic dropEn = 0;
  logic [2:0] dropAt = '0;
  logic rxDatVld;

  assign rxDatVld = datLaneVld && !(dropEn && slotIdx == dropAt);

  pbus_top u0 (
    .clk(clk), .rstN(rstN),
    .rowInVld(rowInVld), .rowInRdy(rowInRdy), .rowIn(rowIn),
    .colInVld(colInVld), .colInRdy(colInRdy), .colIn(colIn),
    .datInVld(datInVld), .datInRdy(datInRdy), .datIn(datIn),
    .slotIdx(slotIdx), .chanRise(chanRise),
    .rowLane(rowLane), .rowLaneVld(rowLaneVld),
    .colLane(colLane), .colLaneVld(colLaneVld),
    .datLane(datLane), .datLaneVld(datLaneVld),
    .rxRowLane(rowLane), .rxRowLaneVld(rowLaneVld),
    .rxColLane(colLane), .rxColLaneVld(colLaneVld),
    .rxDatLane(datLane), .rxDatLaneVld(rxDatVld),
    .rowOut(rowOut), .rowOutVld(rowOutVld),
    .colOut(colOut), .colOutVld(colOutVld),
    .datOut(datOut), .datOutVld(datOutVld));

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [143:0] mkDat(input int p);
    logic [143:0] d;
    for (int i = 0; i < 8; i++) d[i*18 +: 18] = 18'((p * 7919 + i * 4099 + 5) ^ (i << p));
    return d;
  endfunction

  task automatic toSlot7();
    while (slotIdx != 3'd7) @(negedge clk);
  endtask

  // drive a packet on selected lanes and check lanes then receive outputs
  task automatic runPkt(input logic [11:0] r, input logic [19:0] c, input logic [143:0] d,
                        input bit uR, input bit uC, input bit uD, input bit drop, input int dAt);
    toSlot7();
    rowIn = r; colIn = c; datIn = d;
    rowInVld = uR; colInVld = uC; datInVld = uD;
    dropEn = drop; dropAt = 3'(dAt);
    @(negedge clk);
    rowInVld = 0; colInVld = 0; datInVld = 0;
    for (int s = 0; s < 8; s++) begin
      chk(slotIdx == 3'(s), "R10 slot in packet", 144'(slotIdx), 144'(s));
      chk(rowLaneVld == uR, "R5/R9 row lane valid", 144'(rowLaneVld), 144'(uR));
      chk(colLaneVld == uC, "R5/R9 col lane valid", 144'(colLaneVld), 144'(uC));
      chk(datLaneVld == uD, "R5/R9 data lane valid", 144'(datLaneVld), 144'(uD));
      if (uD) chk(datLane == d[s*18 +: 18], "R3 data beat", 144'(datLane), 144'(d[s*18 +: 18]));
      if (uR) chk(rowLane == r[(s/2)*3 +: 3], "R4 row beat", 144'(rowLane), 144'(r[(s/2)*3 +: 3]));
      if (uC) chk(colLane == c[(s/2)*5 +: 5], "R4 col beat", 144'(colLane), 144'(c[(s/2)*5 +: 5]));
      @(negedge clk);
    end
    chk(rowOutVld == uR, "R7/R9 row out valid", 144'(rowOutVld), 144'(uR));
    chk(colOutVld == uC, "R7/R9 col out valid", 144'(colOutVld), 144'(uC));
    chk(datOutVld == (uD && !drop), "R7/R8 data out valid", 144'(datOutVld), 144'(uD && !drop));
    if (uR) chk(rowOut == r, "R7 row word", 144'(rowOut), 144'(r));
    if (uC) chk(colOut == c, "R7 col word", 144'(colOut), 144'(c));
    if (uD && !drop) chk(datOut == d, "R7 data word", datOut, d);
    chk(!rowLaneVld && !colLaneVld && !datLaneVld, "R5 idle frame lanes low",
        144'({rowLaneVld, colLaneVld, datLaneVld}), 144'(0));
    @(negedge clk);
    chk(!rowOutVld && !colOutVld && !datOutVld, "R7 single-cycle pulse",
        144'({rowOutVld, colOutVld, datOutVld}), 144'(0));
    dropEn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(slotIdx == 0, "R1 slot in reset", 144'(slotIdx), 144'(0));
    chk(!rowLaneVld && !colLaneVld && !datLaneVld, "R1 lane valids in reset",
        144'({rowLaneVld, colLaneVld, datLaneVld}), 144'(0));
    rstN = 1;
    #1;
    chk(!rowOutVld && !colOutVld && !datOutVld, "R1 out valids after reset",
        144'({rowOutVld, colOutVld, datOutVld}), 144'(0));
    chk(slotIdx == 0, "R1 slot after reset", 144'(slotIdx), 144'(0));
    @(negedge clk);
    // R2 / R10 sweep
    for (int i = 0; i < 24; i++) begin
      logic [2:0] prev;
      prev = slotIdx;
      chk(rowInRdy == (slotIdx == 7) && colInRdy == (slotIdx == 7) && datInRdy == (slotIdx == 7),
          "R2 ready only in slot 7", 144'({rowInRdy, colInRdy, datInRdy}), 144'({3{slotIdx == 7}}));
      chk(chanRise == !slotIdx[0], "R10 rise phase", 144'(chanRise), 144'(!slotIdx[0]));
      @(negedge clk);
      chk(slotIdx == 3'(prev + 1), "R10 slot step", 144'(slotIdx), 144'(3'(prev + 1)));
    end
    // R3 R4 R7 over many patterns on all lanes
    for (int p = 0; p < 12; p++)
      runPkt(12'((p * 2477 + 11) ^ (p << 7)), 20'((p * 344563 + 3) ^ (p << 13)), mkDat(p),
             1, 1, 1, 0, 0);
    // corner words
    runPkt(12'hFFF, 20'hFFFFF, {144{1'b1}}, 1, 1, 1, 0, 0);
    runPkt(12'h000, 20'h00000, '0, 1, 1, 1, 0, 0);
    // R9 independence
    runPkt(12'hA5C, 20'h0, '0, 1, 0, 0, 0, 0);
    runPkt(12'h0, 20'h3C5A1, '0, 0, 1, 0, 0, 0);
    runPkt(12'h0, 20'h0, mkDat(20), 0, 0, 1, 0, 0);
    // R8 drop in each slot position
    for (int k = 0; k < 8; k++) runPkt(12'(k * 300 + 1), 20'(k * 9001), mkDat(30 + k), 1, 1, 1, 1, k);
    // R6 back-to-back
    toSlot7();
    datIn = mkDat(40); datInVld = 1;
    @(negedge clk);
    datIn = mkDat(41);
    for (int s = 0; s < 8; s++) begin
      chk(datLaneVld && datLane == mkDat(40)[s*18 +: 18], "R6 first packet beat",
          144'(datLane), 144'(mkDat(40)[s*18 +: 18]));
      @(negedge clk);
    end
    datInVld = 0;
    chk(datOutVld && datOut == mkDat(40), "R6 first word", datOut, mkDat(40));
    for (int s = 0; s < 8; s++) begin
      chk(datLaneVld && datLane == mkDat(41)[s*18 +: 18], "R6 second packet no gap",
          144'(datLane), 144'(mkDat(41)[s*18 +: 18]));
      @(negedge clk);
    end
    chk(datOutVld && datOut == mkDat(41), "R6 second word", datOut, mkDat(41));
    chk(!datLaneVld, "R5 lane drops after last packet", 144'(datLaneVld), 144'(0));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule